// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block lets an external host reach a processor's on-chip data memory (16-bit words) and program memory (24-bit words) through one 16-bit bus that carries both address and data at different times. The host first runs an address phase. It drives a word that holds a memory address and a memory-select bit, then drops the address-latch input. After that it runs any number of read or write transfers. The port keeps its own copy of the address and advances it after each completed word. A block of consecutive words therefore needs only its start address.

The host side runs without a clock. Every host control input is brought into the core clock domain through a synchronizer. The port lowers its ready output while a transfer is in progress and raises it again when the core-side work is done. On the core side, each memory access is a one-cycle request with a write-enable, a memory select, an address and write data. Read data comes back in the cycle that follows the request. A program-memory word takes two bus transfers: the upper sixteen bits move first, then the low byte, right-justified. Data-memory writes into a protected window at the top of the address space are suppressed, because that window holds control registers.

Top module: `host_mem_port`

## Requirements
- R1: While reset is held and right after it, `host_ack` is 1, `host_bus_oe` is 0 and `mem_req` is 0.
- R2: In an address phase, bus bits [13:0] give the word address and bit 14 picks the memory (1 = program memory, 0 = data memory). The port captures them when the synchronized `host_alat` falls. Bit 15 is ignored.
- R3: A transfer starts when `host_sel_n` is low together with `host_rd_n` or `host_wr_n` low. `host_ack` goes low, then returns high exactly SYNC_STAGES+4 core clock rising edges after the edge that first samples the strobe. That count covers the synchronizer, one synchronization cycle, one memory cycle and one capture cycle.
- R4: Every data-memory read transfer issues exactly one `mem_req` with `mem_we` low, and `mem_req` never stays high for two cycles in a row.
- R5: On a data-memory read, `host_bus_out` shows the 16-bit word with `host_bus_oe` high from the moment `host_ack` rises until the strobes have been released. After release, `host_bus_oe` returns to 0.
- R6: A data-memory write below the protected window stores the 16-bit bus word with exactly one write request.
- R7: Program-memory writes take two transfers. The first gives bits [23:8] and makes no memory request. The second gives bits [7:0] in bus bits [7:0] and issues the single 24-bit write.
- R8: Program-memory reads take two transfers. The first issues one memory read and returns bits [23:8]. The second makes no request and returns {8'h00, bits [7:0]}.
- R9: The address advances by one after each data-memory transfer, and after the second transfer of each program-memory word.
- R10: The address wraps from 0x3FFF to 0x0000, and the memory-select bit is unchanged by the wrap.
- R11: A data-memory write at an address at or above CTRL_BASE (default 0x3FE0) issues no memory request. The address still advances and `host_ack` still completes. Reads there are normal.
- R12: A new address phase restarts the program-memory word split at the upper part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_alat | input | 1 | Address-latch strobe; falling edge loads the address |
| host_sel_n | input | 1 | Port select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_bus_in | input | 16 | Bus value driven by the host |
| host_bus_out | output | 16 | Read data toward the host |
| host_bus_oe | output | 1 | Drive enable for `host_bus_out` |
| host_ack | output | 1 | Ready; low while a transfer is in progress |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Request is a write |
| mem_is_pm | output | 1 | Request targets program memory |
| mem_addr | output | 14 | Word address of the request |
| mem_wdata | output | 24 | Write data (data memory uses bits [15:0]) |
| mem_rdata | input | 24 | Read data, valid the cycle after the request |

## Verification
The bench builds the port with its defaults: a 14-bit address, a 16-bit bus, 24-bit program words, two synchronizer stages and CTRL_BASE at 0x3FE0. Because the protected window and the wrap point are both at the top of that address space, a single address phase near 0x3FFF reaches both. With two synchronizer stages, the exact ready latency of six edges can be counted on every transfer. Random address phases, reads and writes that mix memory types and split-word states are checked against a bench model of both memories and of the port's address and split state.

// File: rtl/hmp_pkg.sv
// Shared types for the host memory port.
// Assumes: nothing beyond IEEE 1800-2017.
package hmp_pkg;

    // Transfer sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNC    = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_HOLD    = 3'd4
    } xfer_state_t;

endpackage

// File: rtl/hmp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous control inputs.
// Assumes: each bit is independent; the host keeps levels stable for several clocks.
module hmp_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // First stage samples the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= d;
    end

    // Remaining stages shift the sample along
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hmp_addr_ctr.sv
// Holds the word address and memory select. Loads on an address phase and
// advances by one on request. The address wraps at its width and the select is kept.
// Assumes: load and advance are never high in the same cycle.
module hmp_addr_ctr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_pm,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              is_pm
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Address register: load from the host or step forward
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (load)    addr <= load_addr;
        else if (advance) addr <= addr + ONE;
    end

    // Memory select: changes only on an address phase
    always_ff @(posedge clk) begin
        if (!rst_n)    is_pm <= 1'b0;
        else if (load) is_pm <= load_pm;
    end

endmodule

// File: rtl/hmp_xfer_ctrl.sv
// Runs one host transfer: waits one synchronization cycle, makes the memory access,
// captures the result, raises ready and waits for the strobes to be released.
// Handles the two-part program-memory word and suppresses writes to the
// protected data-memory window.
// Assumes: rd_act/wr_act are already synchronized; the host holds bus_in stable
// while a write strobe is held.
module hmp_xfer_ctrl
    import hmp_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BUS_W     = 16,
    parameter int PM_W      = 24,
    parameter int CTRL_BASE = 'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic              latch_evt,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_pm,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic              idle,
    output logic              ack,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PM_W-1:0]   mem_wdata,
    output logic              advance
);

    localparam int                LO_W     = PM_W - BUS_W;
    localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_BASE);

    xfer_state_t      state;
    logic             dir_rd;
    logic             half;
    logic [BUS_W-1:0] wdata_q;
    logic [BUS_W-1:0] hi_hold;
    logic [LO_W-1:0]  lo_hold;
    logic             need_mem;
    logic             start;

    assign start = rd_act | wr_act;
    assign idle  = (state == ST_IDLE);

    // Decide whether this transfer touches the memory array
    always_comb begin
        if (dir_rd)      need_mem = !cur_pm || !half;
        else if (cur_pm) need_mem = half;
        else             need_mem = (cur_addr < CTRL_LIM);
    end

    assign mem_req   = (state == ST_ACCESS) && need_mem;
    assign mem_we    = !dir_rd;
    assign mem_wdata = cur_pm ? {hi_hold, wdata_q[LO_W-1:0]} : {{LO_W{1'b0}}, wdata_q};
    assign advance   = (state == ST_CAPTURE) && (!cur_pm || half);
    assign bus_oe    = (state == ST_HOLD) && dir_rd;

    // Sequencer for one transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    if (start) state <= ST_SYNC;
                ST_SYNC:    state <= ST_ACCESS;
                ST_ACCESS:  state <= ST_CAPTURE;
                ST_CAPTURE: state <= ST_HOLD;
                ST_HOLD:    if (!start) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Ready output: low from transfer start until the capture step
    always_ff @(posedge clk) begin
        if (!rst_n)                          ack <= 1'b1;
        else if (idle && start)              ack <= 1'b0;
        else if (state == ST_CAPTURE)        ack <= 1'b1;
    end

    // Direction and write word captured when the transfer starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd  <= 1'b0;
            wdata_q <= '0;
        end else if (idle && start) begin
            dir_rd  <= rd_act;
            wdata_q <= bus_in;
        end
    end

    // Split-word phase: cleared by an address phase, flips per program transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                                half <= 1'b0;
        else if (latch_evt)                        half <= 1'b0;
        else if ((state == ST_CAPTURE) && cur_pm)  half <= ~half;
    end

    // Upper part of a program word being written
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_hold <= '0;
        else if ((state == ST_CAPTURE) && !dir_rd && cur_pm && !half)
            hi_hold <= wdata_q;
    end

    // Lower byte of a program word read, kept for the second transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_hold <= '0;
        else if ((state == ST_CAPTURE) && dir_rd && cur_pm && !half)
            lo_hold <= mem_rdata[LO_W-1:0];
    end

    // Read data register toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
        end else if ((state == ST_CAPTURE) && dir_rd) begin
            if (!cur_pm)    bus_out <= mem_rdata[BUS_W-1:0];
            else if (!half) bus_out <= mem_rdata[PM_W-1:LO_W];
            else            bus_out <= {{(BUS_W-LO_W){1'b0}}, lo_hold};
        end
    end

endmodule

// File: rtl/host_mem_port.sv
// Top of the host memory port. Synchronizes the host controls, detects the
// address phase, and ties the address counter to the transfer sequencer.
// Assumes: ADDR_W < BUS_W < PM_W; the host keeps the bus stable until ready.
module host_mem_port #(
    parameter int ADDR_W      = 14,
    parameter int BUS_W       = 16,
    parameter int PM_W        = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_BASE   = 'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_alat,
    input  logic              host_sel_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [BUS_W-1:0]  host_bus_in,
    output logic [BUS_W-1:0]  host_bus_out,
    output logic              host_bus_oe,
    output logic              host_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_is_pm,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    input  logic [PM_W-1:0]   mem_rdata
);

    localparam int N_CTL = 4;

    logic [N_CTL-1:0]  ctl_s;
    logic              alat_s, sel_n_s, rd_n_s, wr_n_s;
    logic              alat_d;
    logic              latch_evt;
    logic              idle;
    logic              advance;
    logic              rd_act, wr_act;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_pm;

    hmp_sync #(
        .WIDTH     (N_CTL),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (4'b0111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_alat, host_sel_n, host_rd_n, host_wr_n}),
        .q     (ctl_s)
    );

    assign {alat_s, sel_n_s, rd_n_s, wr_n_s} = ctl_s;
    assign rd_act    = !sel_n_s && !rd_n_s;
    assign wr_act    = !sel_n_s && !wr_n_s;
    assign latch_evt = alat_d && !alat_s && idle;

    // Previous synchronized latch level, for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) alat_d <= 1'b0;
        else        alat_d <= alat_s;
    end

    hmp_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (latch_evt),
        .load_addr (host_bus_in[ADDR_W-1:0]),
        .load_pm   (host_bus_in[ADDR_W]),
        .advance   (advance),
        .addr      (cur_addr),
        .is_pm     (cur_pm)
    );

    hmp_xfer_ctrl #(
        .ADDR_W    (ADDR_W),
        .BUS_W     (BUS_W),
        .PM_W      (PM_W),
        .CTRL_BASE (CTRL_BASE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .latch_evt (latch_evt),
        .bus_in    (host_bus_in),
        .cur_addr  (cur_addr),
        .cur_pm    (cur_pm),
        .mem_rdata (mem_rdata),
        .idle      (idle),
        .ack       (host_ack),
        .bus_out   (host_bus_out),
        .bus_oe    (host_bus_oe),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .advance   (advance)
    );

    assign mem_addr  = cur_addr;
    assign mem_is_pm = cur_pm;

endmodule

// File: rtl/hmp_checker.sv
// Protocol properties of the host memory port, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module hmp_checker #(
    parameter int ADDR_W    = 14,
    parameter int CTRL_BASE = 'h3FE0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_bus_oe,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_is_pm,
    input logic [ADDR_W-1:0] mem_addr
);

    localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_BASE);

    // R11: no write request reaches the protected data-memory window
    a_r11_ctrl_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_is_pm) |-> (mem_addr < CTRL_LIM));

    // R4: a memory request lasts a single cycle
    a_r4_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3: ready is low while the memory is being accessed
    a_r3_busy_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !host_ack);

    // R3: ready is still low in the capture cycle after the access
    a_r3_busy_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !host_ack);

    // R5: read data is driven only while ready is high
    a_r5_drive_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        host_bus_oe |-> host_ack);

endmodule

bind host_mem_port hmp_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE)
) u_hmp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ack    (host_ack),
    .host_bus_oe (host_bus_oe),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_is_pm   (mem_is_pm),
    .mem_addr    (mem_addr)
);

// File: tb/test_host_mem_port.sv
module test_host_mem_port;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int CTRL_BASE  = 'h3FE0;
    localparam int AMASK      = 'h3FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_alat = 1'b0;
    logic        host_sel_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [15:0] host_bus_in = '0;
    logic [15:0] host_bus_out;
    logic        host_bus_oe;
    logic        host_ack;
    logic        mem_req;
    logic        mem_we;
    logic        mem_is_pm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    // memory model contents and independent expected contents
    logic [15:0] mdl_dm [int];
    logic [23:0] mdl_pm [int];
    logic [15:0] exp_dm [int];
    logic [23:0] exp_pm [int];

    // expected port state
    int          e_addr = 0;
    bit          e_pm   = 1'b0;
    bit          e_half = 1'b0;
    logic [15:0] e_hi   = '0;
    logic [7:0]  e_lo   = '0;

    host_mem_port #(
        .SYNC_STAGES (SYNC),
        .CTRL_BASE   (CTRL_BASE)
    ) i_host_mem_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_alat    (host_alat),
        .host_sel_n   (host_sel_n),
        .host_rd_n    (host_rd_n),
        .host_wr_n    (host_wr_n),
        .host_bus_in  (host_bus_in),
        .host_bus_out (host_bus_out),
        .host_bus_oe  (host_bus_oe),
        .host_ack     (host_ack),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_is_pm    (mem_is_pm),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] dflt_dm(int a);
        logic [13:0] x = 14'(a);
        return {x[1:0], ~x};
    endfunction

    function automatic logic [23:0] dflt_pm(int a);
        logic [13:0] x = 14'(a);
        return {~x[9:0], x};
    endfunction

    // behavioural memory: one-cycle request, data the next cycle
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                wr_cnt++;
                if (mem_is_pm) mdl_pm[int'(mem_addr)] = mem_wdata;
                else           mdl_dm[int'(mem_addr)] = mem_wdata[15:0];
            end else begin
                rd_cnt++;
                if (mem_is_pm)
                    mem_rdata <= mdl_pm.exists(int'(mem_addr)) ? mdl_pm[int'(mem_addr)] : dflt_pm(int'(mem_addr));
                else
                    mem_rdata <= {8'h00, mdl_dm.exists(int'(mem_addr)) ? mdl_dm[int'(mem_addr)] : dflt_dm(int'(mem_addr))};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // address phase; bit15 lets the bench put junk in the ignored bit
    task automatic host_latch(input int a, input bit pm, input bit b15);
        host_bus_in = {b15, pm, 14'(a)};
        host_alat = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
        host_alat = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        e_addr = a & AMASK;
        e_pm   = pm;
        e_half = 1'b0;
    endtask

    // one bus transfer with ready-latency check (R3)
    task automatic host_xfer(input bit is_rd, input logic [15:0] wd, output logic [15:0] rd);
        int n;
        bit saw_low;
        host_bus_in = wd;
        host_sel_n  = 1'b0;
        if (is_rd) host_rd_n = 1'b0;
        else       host_wr_n = 1'b0;
        n = 0;
        saw_low = 1'b0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!host_ack) saw_low = 1'b1;
        end while (!(host_ack && saw_low) && n < 40);
        chk(n == SYNC + 4, "R3 ready latency", n, SYNC + 4);
        rd = host_bus_out;
        if (is_rd) chk(host_bus_oe == 1'b1, "R5 drive while strobe held", host_bus_oe, 1);
        host_sel_n = 1'b1;
        host_rd_n  = 1'b1;
        host_wr_n  = 1'b1;
        repeat (SYNC + 2) @(negedge clk);
        chk(host_bus_oe == 1'b0, "R5 drive released", host_bus_oe, 0);
    endtask

    task automatic host_write(input logic [15:0] wd, input string tag);
        int wb, exp_w;
        logic [15:0] dummy;
        wb = wr_cnt;
        if (!e_pm) begin
            exp_w = (e_addr < CTRL_BASE) ? 1 : 0;
            if (exp_w == 1) exp_dm[e_addr] = wd;
            e_addr = (e_addr + 1) & AMASK;
        end else if (!e_half) begin
            e_hi = wd;
            exp_w = 0;
            e_half = 1'b1;
        end else begin
            exp_pm[e_addr] = {e_hi, wd[7:0]};
            exp_w = 1;
            e_half = 1'b0;
            e_addr = (e_addr + 1) & AMASK;
        end
        host_xfer(1'b0, wd, dummy);
        chk((wr_cnt - wb) == exp_w, tag, wr_cnt - wb, exp_w);
    endtask

    task automatic host_read(input string tag, output logic [15:0] got);
        int rb, exp_r;
        logic [15:0] ev;
        logic [23:0] w;
        rb = rd_cnt;
        if (!e_pm) begin
            ev = exp_dm.exists(e_addr) ? exp_dm[e_addr] : dflt_dm(e_addr);
            exp_r = 1;
            e_addr = (e_addr + 1) & AMASK;
        end else if (!e_half) begin
            w = exp_pm.exists(e_addr) ? exp_pm[e_addr] : dflt_pm(e_addr);
            ev = w[23:8];
            e_lo = w[7:0];
            exp_r = 1;
            e_half = 1'b1;
        end else begin
            ev = {8'h00, e_lo};
            exp_r = 0;
            e_half = 1'b0;
            e_addr = (e_addr + 1) & AMASK;
        end
        host_xfer(1'b1, 16'h0, got);
        chk(got == ev, tag, got, ev);
        chk((rd_cnt - rb) == exp_r, e_pm ? "R8 read request count" : "R4 read request count", rd_cnt - rb, exp_r);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int r;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(host_ack == 1'b1, "R1 ack in reset", host_ack, 1);
        chk(host_bus_oe == 1'b0, "R1 oe in reset", host_bus_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(host_ack == 1'b1, "R1 ack after reset", host_ack, 1);
        chk(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);

        // R6, R9: sequential data-memory writes then read-back
        host_latch('h0010, 1'b0, 1'b0);
        host_write(16'h1111, "R6 dm write");
        host_write(16'h2222, "R6 dm write");
        host_write(16'h3333, "R6 dm write");
        host_latch('h0010, 1'b0, 1'b0);
        host_read("R9 auto increment word0", v);
        host_read("R9 auto increment word1", v);
        host_read("R9 auto increment word2", v);
        host_read("R5 dm read default", v);

        // R2: bit 15 ignored, bit 14 selects memory
        host_latch('h0011, 1'b0, 1'b1);
        host_read("R2 latch ignores bit15", v);
        chk(v == 16'h2222, "R2 address captured", v, 16'h2222);

        // R7, R8: program-memory split words
        host_latch('h0100, 1'b1, 1'b0);
        host_write(16'hABCD, "R7 pm upper no request");
        host_write(16'h00EF, "R7 pm lower write");
        host_write(16'h1357, "R7 pm upper no request");
        host_write(16'hFF9B, "R7 pm lower write");
        host_latch('h0100, 1'b1, 1'b0);
        host_read("R8 pm upper", v);
        chk(v == 16'hABCD, "R8 pm upper value", v, 16'hABCD);
        host_read("R8 pm lower", v);
        chk(v == 16'h00EF, "R8 pm lower value", v, 16'h00EF);
        host_read("R8 pm upper next", v);
        host_read("R8 pm lower next", v);

        // R12: address phase restarts the split
        host_latch('h0100, 1'b1, 1'b0);
        host_write(16'h4444, "R12 upper part pending");
        host_latch('h0100, 1'b1, 1'b0);
        host_read("R12 split restarts at upper", v);
        chk(v == 16'hABCD, "R12 upper value kept", v, 16'hABCD);

        // R10: wrap in data memory and in program memory
        host_latch('h3FFF, 1'b0, 1'b0);
        host_read("R10 dm last word", v);
        host_read("R10 dm wrapped", v);
        chk(v == dflt_dm(0), "R10 dm wrapped to zero", v, dflt_dm(0));
        host_latch('h3FFF, 1'b1, 1'b0);
        host_write(16'h5A5A, "R10 pm upper at top");
        host_write(16'h0033, "R10 pm lower at top");
        host_write(16'h6B6B, "R10 pm upper after wrap");
        host_write(16'h0044, "R10 pm lower after wrap");
        host_latch('h0000, 1'b1, 1'b0);
        host_read("R10 pm type kept", v);
        chk(v == 16'h6B6B, "R10 pm wrapped word", v, 16'h6B6B);
        host_read("R10 pm wrapped lower", v);

        // R11: protected window writes dropped, address still moves
        host_latch('h3FE5, 1'b0, 1'b0);
        host_write(16'hBEEF, "R11 blocked write no request");
        host_write(16'hCAFE, "R11 blocked write no request");
        host_latch('h3FE5, 1'b0, 1'b0);
        host_read("R11 blocked word unchanged", v);
        chk(v == dflt_dm('h3FE5), "R11 old value", v, dflt_dm('h3FE5));
        host_read("R11 address advanced", v);
        host_latch('h3FDF, 1'b0, 1'b0);
        host_write(16'h7777, "R6 last writable word");

        // random mix of address phases, reads and writes
        for (int i = 0; i < 80; i++) begin
            r = $urandom_range(0, 9);
            if (r < 2) begin
                if ($urandom_range(0, 1) == 1)
                    host_latch('h3FF0 + $urandom_range(0, 15), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                else
                    host_latch($urandom_range(0, AMASK), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end else if (r < 6) begin
                host_write(16'($urandom), "R6 R7 random write");
            end else begin
                host_read("R5 R8 random read", v);
            end
        end

        finish_run();
    end

endmodule